// File: doc/BRIEF.md
# Processor clock source selector

This block is the control side of the processor clock multiplexer. It chooses between three sources: the 1X reference clock, the synthesizer output and the internal slow clock. It holds a small configuration word with the two select bits, the synthesizer power-down bit and the frequency multiplier. From that word and a synchronised lock indication it drives three clock-gate enables and a select code to a glitch-free clock multiplexer. All of its logic runs on the reference clock. The synthesizer and the oscillator are outside the block: only their lock indication comes in, and only the power-down and multiplier controls go out.

Every change of source is sequenced. First the enable of the old clock is dropped. A fixed gap follows, during which the multiplexer select moves to the new source. Only after the gap is the enable of the new clock raised, so no shortened pulse can reach the processor. When the slow clock is selected it always wins. A selected synthesizer is then left powered and running, so that it is ready when the override ends.

Top module: `pclk_src_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, the reference clock is the engaged source: stat_src_o = 0, clk_en_ref_o = 1, clk_en_pll_o = 0, clk_en_slow_o = 0, clk_mux_sel_o = 0 and stat_busy_o = 0. Source codes are reference 0, synthesizer 1, slow clock 2.
- R2: Reset clears the synthesizer select bit and sets the power-down bit, so pll_pwrdn_o = 1. It also loads the multiplier with MULT_RST.
- R3: A write with cfg_we = 1 loads the configuration word on the next edge. Its fields are: bit 0 synthesizer select, bit 1 slow select, bit 2 synthesizer power-down, bits [3 +: MULT_W] multiplier. pll_pwrdn_o and pll_mult_o show the stored fields. With cfg_we = 0 the stored configuration does not change.
- R4: When slow select is 1, the wanted source is the slow clock, whatever the synthesizer select, power-down and lock state are.
- R5: pll_pwrdn_o depends only on the stored power-down bit. It stays 0 while the slow clock overrides a selected synthesizer.
- R6: The synthesizer is wanted only when its select is 1, its power-down is 0, slow select is 0 and the lock indication is 1 after SYNC_STAGES flip-flops. stat_lock_o shows that synchronised lock.
- R7: At most one of the three clock enables is high in any cycle.
- R8: A switch starts on the edge after the wanted source differs from the engaged one. From then on all enables are 0, clk_mux_sel_o shows the new code and stat_busy_o = 1 for GAP_CYC cycles. After that the new enable rises and stat_src_o takes the new code.
- R9: If, at the end of a gap, the wanted source differs from the one the gap was started for, the gap starts again for the newly wanted source. No enable rises for the abandoned source.
- R10: If lock is lost while the synthesizer is engaged, the block switches back to the reference clock by the sequence of R8.
- R11: stat_src_o shows the last engaged source. In a cycle with any enable high, that source is the one whose enable is high, and it equals clk_mux_sel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference (1X) clock; all logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3+MULT_W | Configuration word (fields in R3) |
| pll_lock_i | input | 1 | Asynchronous synthesizer lock indication |
| pll_pwrdn_o | output | 1 | Synthesizer power-down control |
| pll_mult_o | output | MULT_W | Synthesizer frequency multiplier |
| clk_en_ref_o | output | 1 | Gate enable of the reference clock |
| clk_en_pll_o | output | 1 | Gate enable of the synthesizer clock |
| clk_en_slow_o | output | 1 | Gate enable of the slow clock |
| clk_mux_sel_o | output | 2 | Clock multiplexer select code |
| stat_src_o | output | 2 | Engaged source code |
| stat_lock_o | output | 1 | Synchronised lock state |
| stat_busy_o | output | 1 | Switch in progress |

## Verification
The bench raises the lock before and after selecting the synthesizer. A design that skipped the lock condition would enable an unlocked clock, and the cycle-by-cycle model would catch the early clk_en_pll_o. It selects the slow clock on top of a running synthesizer and checks that power-down stays low. A design that tied power-down to the override would stop the synthesizer. It also changes the wanted source inside a gap. A design that committed the stale target would pulse the synthesizer enable, and one that overlapped the enables, or raised the new one before GAP_CYC cycles, shows a mismatch on the first wrong cycle. Long random runs of writes and lock toggles compare every output on every cycle.

// File: rtl/pclk_sel_pkg.sv
`timescale 1ns/1ps
package pclk_sel_pkg;

    localparam int N_SRC        = 3;
    localparam int SRC_W        = 2;
    localparam int CFG_FIXED_W  = 3;
    localparam int BIT_PLL_SEL  = 0;
    localparam int BIT_SLOW_SEL = 1;
    localparam int BIT_PLL_PD   = 2;
    localparam int MULT_LSB     = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_REF  = 2'd0,
        SRC_PLL  = 2'd1,
        SRC_SLOW = 2'd2
    } src_e;

    typedef enum logic {
        SW_RUN = 1'b0,
        SW_GAP = 1'b1
    } sw_state_e;

    typedef struct packed {
        logic pll_pwrdn;
        logic slow_sel;
        logic pll_sel;
    } ctl_bits_t;

    // Wanted source: slow clock first, then a locked and powered synthesizer.
    function automatic src_e want_src(ctl_bits_t c, logic lock_s);
        if (c.slow_sel)
            return SRC_SLOW;
        else if (c.pll_sel && !c.pll_pwrdn && lock_s)
            return SRC_PLL;
        else
            return SRC_REF;
    endfunction

endpackage

// File: rtl/pclk_cfg_regs.sv
`timescale 1ns/1ps
module pclk_cfg_regs
    import pclk_sel_pkg::*;
#(
    parameter int MULT_W   = 4,
    parameter int MULT_RST = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [CFG_FIXED_W+MULT_W-1:0] wdata,
    output ctl_bits_t                     ctl_q,
    output logic [MULT_W-1:0]             mult_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.pll_sel   <= 1'b0;
            ctl_q.slow_sel  <= 1'b0;
            ctl_q.pll_pwrdn <= 1'b1;
            mult_q          <= MULT_W'(MULT_RST);
        end else if (we) begin
            ctl_q.pll_sel   <= wdata[BIT_PLL_SEL];
            ctl_q.slow_sel  <= wdata[BIT_SLOW_SEL];
            ctl_q.pll_pwrdn <= wdata[BIT_PLL_PD];
            mult_q          <= wdata[MULT_LSB +: MULT_W];
        end
    end

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(ctl_q) && $stable(mult_q)));

endmodule

// File: rtl/pclk_lock_sync.sv
`timescale 1ns/1ps
module pclk_lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pclk_switch_seq.sv
`timescale 1ns/1ps
module pclk_switch_seq
    import pclk_sel_pkg::*;
#(
    parameter int GAP_CYC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  src_e             want,
    output logic [N_SRC-1:0] en,
    output src_e             sel,
    output src_e             cur,
    output logic             busy
);

    localparam int CNT_W = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC);

    sw_state_e        st;
    src_e             pend;
    logic [CNT_W-1:0] cnt;
    logic             gap_done;

    assign gap_done = (cnt == CNT_W'(GAP_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SW_RUN;
            cur  <= SRC_REF;
            pend <= SRC_REF;
            cnt  <= '0;
        end else begin
            case (st)
                SW_RUN: begin
                    if (want != cur) begin
                        st   <= SW_GAP;
                        pend <= want;
                        cnt  <= '0;
                    end
                end
                SW_GAP: begin
                    if (!gap_done) begin
                        cnt <= cnt + 1'b1;
                    end else if (want == pend) begin
                        st  <= SW_RUN;
                        cur <= pend;
                    end else begin
                        pend <= want;
                        cnt  <= '0;
                    end
                end
                default: st <= SW_RUN;
            endcase
        end
    end

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_en
            assign en[g] = (st == SW_RUN) && (cur == src_e'(g));
        end
    endgenerate

    assign sel  = (st == SW_RUN) ? cur : pend;
    assign busy = (st == SW_GAP);

    // R7
    en_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(en));

    // R8
    sel_steady_chk: assert property (@(posedge clk) disable iff (rst)
        ((|en) && $past(|en)) |-> (sel == $past(sel)));

    // R9
    engage_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(busy)) |-> (sel == $past(sel)));

endmodule

// File: rtl/pclk_src_ctrl.sv
`timescale 1ns/1ps
module pclk_src_ctrl
    import pclk_sel_pkg::*;
#(
    parameter int MULT_W      = 4,
    parameter int MULT_RST    = 2,
    parameter int SYNC_STAGES = 2,
    parameter int GAP_CYC     = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [CFG_FIXED_W+MULT_W-1:0] cfg_wdata,
    input  logic                          pll_lock_i,
    output logic                          pll_pwrdn_o,
    output logic [MULT_W-1:0]             pll_mult_o,
    output logic                          clk_en_ref_o,
    output logic                          clk_en_pll_o,
    output logic                          clk_en_slow_o,
    output logic [SRC_W-1:0]              clk_mux_sel_o,
    output logic [SRC_W-1:0]              stat_src_o,
    output logic                          stat_lock_o,
    output logic                          stat_busy_o
);

    ctl_bits_t        ctl;
    logic             lock_s;
    src_e             want;
    src_e             sel;
    src_e             cur;
    logic [N_SRC-1:0] en;
    logic             pll_ready;

    pclk_cfg_regs #(
        .MULT_W   (MULT_W),
        .MULT_RST (MULT_RST)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .ctl_q  (ctl),
        .mult_q (pll_mult_o)
    );

    pclk_lock_sync #(
        .STAGES (SYNC_STAGES)
    ) u_lock (
        .clk (clk),
        .rst (rst),
        .d   (pll_lock_i),
        .q   (lock_s)
    );

    assign want = want_src(ctl, lock_s);

    pclk_switch_seq #(
        .GAP_CYC (GAP_CYC)
    ) u_seq (
        .clk  (clk),
        .rst  (rst),
        .want (want),
        .en   (en),
        .sel  (sel),
        .cur  (cur),
        .busy (stat_busy_o)
    );

    assign clk_en_ref_o  = en[SRC_REF];
    assign clk_en_pll_o  = en[SRC_PLL];
    assign clk_en_slow_o = en[SRC_SLOW];
    assign clk_mux_sel_o = sel;
    assign stat_src_o    = cur;
    assign stat_lock_o   = lock_s;
    assign pll_pwrdn_o   = ctl.pll_pwrdn;

    assign pll_ready = ctl.pll_sel & ~ctl.pll_pwrdn & ~ctl.slow_sel & lock_s;

    // R6
    pll_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        clk_en_pll_o |-> $past(pll_ready));

    // R5
    pwrdn_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(cfg_we) && $past(ctl.slow_sel)) |-> (pll_pwrdn_o == $past(pll_pwrdn_o)));

endmodule

// File: tb/test_pclk_src_ctrl.sv
`timescale 1ns/1ps
module test_pclk_src_ctrl;

    localparam int MULT_W   = 4;
    localparam int MULT_RST = 2;
    localparam int SYNC     = 2;
    localparam int GAP      = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [3+MULT_W-1:0] cfg_wdata = '0;
    logic              pll_lock = 1'b0;
    logic              pll_pwrdn;
    logic [MULT_W-1:0] pll_mult;
    logic              en_ref, en_pll, en_slow;
    logic [1:0]        mux_sel, st_src;
    logic              st_lock, st_busy;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pclk_src_ctrl #(
        .MULT_W (MULT_W), .MULT_RST (MULT_RST), .SYNC_STAGES (SYNC), .GAP_CYC (GAP)
    ) i_pclk_src_ctrl (
        .clk (clk), .rst (rst), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .pll_lock_i (pll_lock), .pll_pwrdn_o (pll_pwrdn), .pll_mult_o (pll_mult),
        .clk_en_ref_o (en_ref), .clk_en_pll_o (en_pll), .clk_en_slow_o (en_slow),
        .clk_mux_sel_o (mux_sel), .stat_src_o (st_src), .stat_lock_o (st_lock),
        .stat_busy_o (st_busy)
    );

    // behavioural reference model
    bit m_psel, m_ssel, m_pd;
    int m_mult, m_state, m_cur, m_pend, m_cnt;
    bit lockq[$];

    function automatic int wanted(bit ps, bit ss, bit pd, bit lk);
        if (ss) return 2;
        if (ps && !pd && lk) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_psel = 0; m_ssel = 0; m_pd = 1; m_mult = MULT_RST;
            m_state = 0; m_cur = 0; m_pend = 0; m_cnt = 0;
            lockq = {};
            for (int i = 0; i < SYNC; i++) lockq.push_back(1'b0);
        end else begin
            int tgt;
            tgt = wanted(m_psel, m_ssel, m_pd, lockq[0]);
            if (m_state == 0) begin
                if (tgt != m_cur) begin m_state = 1; m_pend = tgt; m_cnt = 0; end
            end else if (m_cnt < GAP - 1) begin
                m_cnt++;
            end else if (tgt == m_pend) begin
                m_state = 0; m_cur = m_pend;
            end else begin
                m_pend = tgt; m_cnt = 0;
            end
            if (cfg_we) begin
                m_psel = cfg_wdata[0]; m_ssel = cfg_wdata[1]; m_pd = cfg_wdata[2];
                m_mult = int'(cfg_wdata[3 +: MULT_W]);
            end
            void'(lockq.pop_front());
            lockq.push_back(pll_lock);
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    bit pll_seen = 1'b0;
    always @(negedge clk) begin
        if (!done && lockq.size() == SYNC) begin
            int run;
            run = (m_state == 0);
            chk("R7 en_ref",  en_ref,  run && m_cur == 0);
            chk("R8 en_pll",  en_pll,  run && m_cur == 1);
            chk("R4 en_slow", en_slow, run && m_cur == 2);
            chk("R8 mux_sel", mux_sel, run ? m_cur : m_pend);
            chk("R11 stat_src", st_src, m_cur);
            chk("R8 busy",    st_busy, m_state);
            chk("R6 lock",    st_lock, lockq[0]);
            chk("R5 pwrdn",   pll_pwrdn, m_pd);
            chk("R3 mult",    pll_mult, m_mult);
            if (en_pll) pll_seen = 1'b1;
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(bit ps, bit ss, bit pd, int mult);
        cfg_we = 1'b1;
        cfg_wdata = {MULT_W'(mult), pd, ss, ps};
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic look(string tag, int r, int p, int s, int src);
        @(negedge clk);
        chk({tag, " en_ref"},  en_ref, r);
        chk({tag, " en_pll"},  en_pll, p);
        chk({tag, " en_slow"}, en_slow, s);
        chk({tag, " src"},     st_src, src);
        step(1);
    endtask

    initial begin
        step(3);
        // R1 R2: reset state
        look("R1 in reset", 1, 0, 0, 0);
        @(negedge clk); chk("R2 pwrdn reset", pll_pwrdn, 1); chk("R2 mult reset", pll_mult, MULT_RST);
        step(0);
        rst = 1'b0;
        step(0);
        look("R1 after reset", 1, 0, 0, 0);

        // R6: selected but unlocked stays on reference
        wr(1, 0, 0, 6);
        step(10);
        look("R6 unlocked", 1, 0, 0, 0);
        @(negedge clk); chk("R3 pwrdn written", pll_pwrdn, 0); chk("R3 mult written", pll_mult, 6);
        step(0);

        // R8: lock arrives, sequenced switch to synthesizer
        pll_lock = 1'b1;
        step(SYNC + 1);
        @(negedge clk); chk("R8 gap busy", st_busy, 1); chk("R8 gap sel", mux_sel, 1);
        chk("R8 gap no enable", en_ref | en_pll | en_slow, 0);
        step(GAP);
        look("R8 engaged pll", 0, 1, 0, 1);

        // R4 R5: slow overrides, synthesizer stays powered
        wr(1, 1, 0, 6);
        step(GAP + 3);
        look("R4 slow wins", 0, 0, 1, 2);
        @(negedge clk); chk("R5 pll powered under override", pll_pwrdn, 0);
        step(0);

        // back to synthesizer, then R10 lock loss
        wr(1, 0, 0, 6);
        step(GAP + 3);
        look("R8 back to pll", 0, 1, 0, 1);
        pll_lock = 1'b0;
        step(SYNC + GAP + 3);
        look("R10 lock lost", 1, 0, 0, 0);

        // R9: target changes inside the gap
        wr(0, 0, 0, 3);
        pll_lock = 1'b1;
        step(SYNC + 2);
        pll_seen = 1'b0;
        wr(1, 0, 0, 3);
        step(1);
        wr(1, 1, 0, 3);
        step(2 * GAP + 4);
        chk("R9 no stale pll enable", int'(pll_seen), 0);
        look("R9 restarted to slow", 0, 0, 1, 2);

        // R6: power-down blocks synthesizer
        wr(1, 0, 1, 3);
        step(GAP + 3);
        look("R6 powered down", 1, 0, 0, 0);

        // random traffic, model compared every cycle
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 15) == 0) pll_lock = ~pll_lock;
            if ($urandom_range(0, 9) == 0) begin
                cfg_we = 1'b1;
                cfg_wdata = (3 + MULT_W)'($urandom);
            end else begin
                cfg_we = 1'b0;
            end
            step(1);
        end
        cfg_we = 1'b0;
        step(2);

        // R2: reset mid-run restores defaults
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(0);
        look("R2 reset again", 1, 0, 0, 0);
        @(negedge clk); chk("R2 pwrdn again", pll_pwrdn, 1);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule